// File: doc/BRIEF.md
# PAM4 Decision-Feedback Slicer with Burst-Tail Repair

This block sits on the receive side of a PAM4 link whose transmitter applies a 1/(1+D) mod-4 precoder. On each qualified cycle it accepts one signed fixed-point sample from the feed-forward equalizer. A one-tap decision-feedback loop subtracts the weighted previous decision, and the result is sliced to a symbol in the range 0 to 3. The sliced stream is then decoded with (1+D) mod 4, which returns the original data symbols.

A wrong DFE decision starts an alternating +1/−1 error run. The precoding decoder cancels every error inside the run except the first and the last. The run ends when the equalized sample falls outside the PAM4 constellation by more than a programmable margin. The block classifies each equalized sample into one of three zones: ZN_INSIDE, ZN_ABOVE and ZN_BELOW. The zone is registered next to the sliced symbol. In the output stage a unique case on that zone selects the repair. ZN_ABOVE adds one mod 4 to the decoded symbol, ZN_BELOW subtracts one, and ZN_INSIDE passes it through. Any zone other than ZN_INSIDE raises the end-of-burst flag. Only the error at the start of a run reaches the output. The zone register moves from one zone to another on every valid sample, as the comparators decide, and holds its value on idle cycles.

Levels sit at integer codes k·2^F. The tap weight is an unsigned Q1.F value, and the margin is given in the same LSB units as the samples.

Top module: `pam4_tail_corrector`

## Requirements
- R1: The equalized value is in_sample minus tap_weight times the previous sliced decision. Both are in units of 2^-F, so a level k sits at k·2^F.
- R2: The slicer rounds the equalized value to the nearest integer level, with an exact half rounding upward, and then clamps the result to 0..3.
- R3: The output symbol is (current slice + previous slice) mod 4, before repair.
- R4: When the equalized value is strictly greater than 3·2^F + margin, out_eob is 1 and the decoded symbol is increased by 1 mod 4. Equality is not flagged.
- R5: When the equalized value is strictly less than −margin, out_eob is 1 and the decoded symbol is decreased by 1 mod 4. Equality is not flagged.
- R6: out_eob is the OR of the two conditions above, and it is never 1 while out_valid is 0.
- R7: A sample presented with in_valid at clock edge n produces out_valid, out_sym and out_eob at edge n+2.
- R8: A cycle with in_valid low changes no state. Two edges later out_valid and out_eob are 0 and out_sym holds its last value.
- R9: With a tap weight equal to the channel post-cursor and one injected decision error, the output stream differs from the data sent only at the symbol where the error began.
- R10: Reset (rst high, synchronous) clears the outputs, the feedback decision and the decoder's previous slice to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies in_sample |
| in_sample | input | W | Signed FFE output, levels at k·2^F |
| tap_weight | input | F+1 | Unsigned Q1.F feedback tap |
| margin | input | W-1 | Unsigned out-of-range margin in sample LSBs |
| out_valid | output | 1 | Output symbol strobe |
| out_sym | output | 2 | Decoded and repaired symbol |
| out_eob | output | 1 | End-of-burst flag |

## Verification
Every result, whether the repaired symbol, the end-of-burst flag or the valid strobe, is due exactly two rising edges after the edge that took its sample. The bench drives on the falling edge and checks on the falling edge two steps later. It keeps a two-deep record of the valid bits it drove, and it pops a list of expected values only when that record says a result is due. On idle slots it checks that out_valid and out_eob are low and that out_sym has held. The burst runs build the channel samples from a random precoded sequence. The tail is placed so that it lands on an overflow for an odd run length and on an underflow for an even one.

// File: rtl/pam4_tail_pkg.sv
package pam4_tail_pkg;

    typedef logic [1:0] sym_t;

    // Where the equalized sample fell relative to the outer levels.
    typedef enum logic [1:0] {
        ZN_INSIDE = 2'd0,
        ZN_ABOVE  = 2'd1,
        ZN_BELOW  = 2'd2
    } zone_t;

endpackage

// File: rtl/pam4_dfe_slicer.sv
module pam4_dfe_slicer
    import pam4_tail_pkg::*;
#(
    parameter int F = 6,
    parameter int W = 10
) (
    input  logic signed [W-1:0] sample,
    input  logic        [F:0]   tap,
    input  logic        [W-2:0] margin,
    input  sym_t                prev_dec,
    output sym_t                dec,
    output zone_t               zone
);
    localparam int EW   = W + 3;
    localparam int HALF = 1 << (F - 1);
    localparam int TOP  = 3 << F;

    logic signed [EW-1:0] x_ext, w_ext, d_ext, prod, eq, rnd, lvl;
    logic signed [EW-1:0] hi_thr, lo_thr;

    always_comb begin
        x_ext  = EW'(sample);
        w_ext  = EW'({1'b0, tap});
        d_ext  = EW'({1'b0, prev_dec});
        prod   = w_ext * d_ext;
        eq     = x_ext - prod;
        rnd    = eq + EW'(HALF);
        lvl    = rnd >>> F;
        hi_thr = EW'(TOP) + EW'({1'b0, margin});
        lo_thr = -EW'({1'b0, margin});

        if (lvl[EW-1])
            dec = 2'd0;
        else if (lvl > EW'(3))
            dec = 2'd3;
        else
            dec = lvl[1:0];

        if (eq > hi_thr)
            zone = ZN_ABOVE;
        else if (eq < lo_thr)
            zone = ZN_BELOW;
        else
            zone = ZN_INSIDE;
    end
endmodule

// File: rtl/pam4_tail_fix.sv
module pam4_tail_fix
    import pam4_tail_pkg::*;
(
    input  sym_t  cur,
    input  sym_t  prev,
    input  zone_t zone,
    output sym_t  fixed
);
    sym_t base;

    always_comb begin
        base = cur + prev;
        unique case (zone)
            ZN_ABOVE: fixed = base + 2'd1;
            ZN_BELOW: fixed = base - 2'd1;
            default:  fixed = base;
        endcase
    end
endmodule

// File: rtl/pam4_tail_corrector.sv
module pam4_tail_corrector
    import pam4_tail_pkg::*;
#(
    parameter int F = 6,
    parameter int W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_sample,
    input  logic        [F:0]   tap_weight,
    input  logic        [W-2:0] margin,
    output logic                out_valid,
    output logic        [1:0]   out_sym,
    output logic                out_eob
);
    // Stage-1 state: the last decision also serves as DFE feedback.
    logic  s1_vld;
    sym_t  s1_sym;
    zone_t s1_zone;
    sym_t  prev_sym;

    sym_t  dec_c;
    zone_t zone_c;
    sym_t  fixed_c;

    pam4_dfe_slicer #(.F(F), .W(W)) u_slice (
        .sample   (in_sample),
        .tap      (tap_weight),
        .margin   (margin),
        .prev_dec (s1_sym),
        .dec      (dec_c),
        .zone     (zone_c)
    );

    pam4_tail_fix u_fix (
        .cur   (s1_sym),
        .prev  (prev_sym),
        .zone  (s1_zone),
        .fixed (fixed_c)
    );

    // Zone / decision state register
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld  <= 1'b0;
            s1_sym  <= 2'd0;
            s1_zone <= ZN_INSIDE;
        end else begin
            s1_vld <= in_valid;
            if (in_valid) begin
                s1_sym  <= dec_c;
                s1_zone <= zone_c;
            end
        end
    end

    // Output process
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_sym  <= 2'd0;
            out_valid <= 1'b0;
            out_sym   <= 2'd0;
            out_eob   <= 1'b0;
        end else begin
            out_valid <= s1_vld;
            out_eob   <= 1'b0;
            if (s1_vld) begin
                prev_sym <= s1_sym;
                out_sym  <= fixed_c;
                out_eob  <= (s1_zone != ZN_INSIDE);
            end
        end
    end
endmodule

// File: rtl/pam4_tail_chk.sv
module pam4_tail_chk #(
    parameter int F = 6,
    parameter int W = 10
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic signed [W-1:0] in_sample,
    input logic        [W-2:0] margin,
    input logic                out_valid,
    input logic        [1:0]   out_sym,
    input logic                out_eob
);
    // R7
    lat_valid_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    // R8
    idle_slot_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !out_valid);

    // R8
    hold_sym_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_sym));

    // R6
    eob_qual_chk: assert property (@(posedge clk) disable iff (rst)
        out_eob |-> out_valid);

    // R5: feedback only lowers the sample, so a sample below -margin must underflow
    low_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_sample < -$signed({1'b0, margin}))) |-> ##2 out_eob);
endmodule

bind pam4_tail_corrector pam4_tail_chk #(.F(F), .W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .margin    (margin),
    .out_valid (out_valid),
    .out_sym   (out_sym),
    .out_eob   (out_eob)
);

// File: tb/pam4_tail_corrector_test.sv
module pam4_tail_corrector_test;
    localparam int F = 6;
    localparam int W = 10;
    localparam time CLK_PERIOD = 10ns;
    localparam int ONE = 1 << F;

    // {sample, expected out_sym, expected out_eob}; tap 0, margin 32, fresh reset
    localparam int TBL [12][3] = '{
        '{  64, 1, 0},   // R3 1+0
        '{ 200, 0, 0},   // R2 rounds to 3, 3+1
        '{ 250, 3, 1},   // R4 overflow, 3+3+1
        '{ -40, 2, 1},   // R5 underflow, 0+3-1
        '{ -20, 0, 0},   // R2 rounds to 0
        '{  95, 1, 0},   // R2 just below half
        '{  96, 3, 0},   // R2 exact half rounds up to 2
        '{ 160, 1, 0},   // R3 3+2
        '{ 224, 2, 0},   // R4 equality not flagged
        '{ 225, 3, 1},   // R4 one above threshold
        '{ -32, 3, 0},   // R5 equality not flagged
        '{ -33, 3, 1}    // R5 one below threshold, 0+0-1
    };

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic signed [W-1:0] in_sample = '0;
    logic        [F:0]   tap_weight = '0;
    logic        [W-2:0] margin = 9'd32;
    logic                out_valid;
    logic        [1:0]   out_sym;
    logic                out_eob;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int    exp_sym [256];
    int    exp_eob [256];
    string exp_tag [256];
    int    wr = 0;
    int    rd = 0;
    bit [1:0] vh = 2'b00;
    int    last_sym = 0;
    logic [31:0] seed = 32'h1234_5678;

    pam4_tail_corrector #(.F(F), .W(W)) uut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .tap_weight (tap_weight),
        .margin     (margin),
        .out_valid  (out_valid),
        .out_sym    (out_sym),
        .out_eob    (out_eob)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string tbl_tag(input int i);
        case (i)
            0, 7:         return "R3";
            2, 8, 9:      return "R4";
            3, 10, 11:    return "R5";
            default:      return "R2";
        endcase
    endfunction

    function automatic int rnd_n(input int n);
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed[30:16]) % n;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One slot: check the result due now (driven two slots ago), then drive.
    task automatic step(input bit v, input int samp, input int esym, input bit eeob,
                        input string tag);
        @(negedge clk);
        if (vh[1]) begin
            chk(out_valid == 1'b1, "R7 out_valid", int'(out_valid), 1);
            chk(int'(out_sym) == exp_sym[rd % 256], exp_tag[rd % 256], int'(out_sym), exp_sym[rd % 256]);
            chk(int'(out_eob) == exp_eob[rd % 256], "R6 out_eob", int'(out_eob), exp_eob[rd % 256]);
            last_sym = int'(out_sym);
            rd++;
        end else begin
            chk(out_valid == 1'b0, "R8 out_valid idle", int'(out_valid), 0);
            chk(out_eob == 1'b0, "R8 out_eob idle", int'(out_eob), 0);
            chk(int'(out_sym) == last_sym, "R8 out_sym hold", int'(out_sym), last_sym);
        end
        in_valid  = v;
        in_sample = W'(samp);
        if (v) begin
            exp_sym[wr % 256] = esym;
            exp_eob[wr % 256] = int'(eeob);
            exp_tag[wr % 256] = tag;
            wr++;
        end
        vh = {vh[0], v};
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        // R10
        chk(out_valid == 1'b0, "R10 out_valid", int'(out_valid), 0);
        chk(out_sym == 2'd0, "R10 out_sym", int'(out_sym), 0);
        chk(out_eob == 1'b0, "R10 out_eob", int'(out_eob), 0);
        rst = 1'b0;
        vh = 2'b00;
        last_sym = 0;
        wr = 0;
        rd = 0;
    endtask

    task automatic flush();
        repeat (2) step(1'b0, 0, 0, 1'b0, "R8");
    endtask

    // Channel c_k + tap*c_(k-1) (integer levels); optional error at k with tail at k+len.
    task automatic run_chan(input int n, input int tap, input int k, input int len,
                            input bit bubbles);
        int cp;
        cp = 0;
        do_reset();
        tap_weight = (F+1)'(tap);
        for (int i = 0; i < n; i++) begin
            int c, d, s, e;
            bit fl;
            string tg;
            int j;
            j = i - k;
            if (k >= 0 && j > 0 && j < len)
                c = (j % 2 == 1) ? rnd_n(3) : 1 + rnd_n(3);
            else if (k >= 0 && j == len)
                c = (len % 2 == 1) ? 3 : 0;
            else if (k >= 0 && j == 0)
                c = 1 + rnd_n(3);
            else
                c = rnd_n(4);
            d  = (c + cp) % 4;
            s  = ONE * c + tap * cp;
            e  = d;
            fl = 1'b0;
            tg = "R1 clean symbol";
            if (k >= 0 && j == 0) begin
                s  = s - ONE;
                e  = (d + 3) % 4;
                tg = "R9 burst start";
            end else if (k >= 0 && j == len) begin
                fl = 1'b1;
                tg = (len % 2 == 1) ? "R4 tail overflow fix" : "R5 tail underflow fix";
            end else if (k >= 0 && j > 0 && j < len) begin
                tg = "R9 inside burst";
            end
            if (bubbles && (i % 4 == 2))
                step(1'b0, -300, 0, 1'b0, "R8");
            step(1'b1, s, e, fl, tg);
            cp = c;
        end
        flush();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R7 watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // Vector table: R2 R3 R4 R5 with no feedback
        do_reset();
        tap_weight = '0;
        margin = 9'd32;
        for (int i = 0; i < 12; i++)
            step(1'b1, TBL[i][0], TBL[i][1], TBL[i][2] != 0, tbl_tag(i));
        flush();

        // R1: full-cursor feedback, clean stream
        run_chan(60, 64, -1, 0, 1'b0);
        // R1 R8: 0.75 tap with idle slots carrying junk samples
        run_chan(60, 48, -1, 0, 1'b1);
        // R9 R4: odd-length burst ending in overflow
        run_chan(80, 64, 20, 5, 1'b0);
        // R9 R5: even-length burst ending in underflow, with idle slots
        run_chan(80, 64, 30, 4, 1'b1);
        // R9 R4: one-symbol burst
        run_chan(40, 64, 10, 1, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule